// File: doc/BRIEF.md
# Static Seven-Segment LCD Driver with Backplane Generation

This block turns a latched decimal reading into the drive signals for a static liquid-crystal panel with three full digits, a leading half digit and a minus sign. It divides the system clock down to a 50% duty backplane square wave. Each segment output carries that same waveform: it is in phase with the backplane when the segment is dark and inverted when the segment is lit. The average voltage across every segment is therefore zero.

A new reading is sampled only at a backplane transition, so segment outputs never move between transitions. An overrange flag replaces the reading with a lone leading "1". A lamp-test input forces every segment on at a constant level, so the panel shows "-1888".

Top module: `lcd_seg_driver`

## Requirements
- R1: After reset `bp` is low and every segment output is low. `bp` then toggles every `HALF_DIV` clock cycles, which gives a 50% square wave of period 2·`HALF_DIV`. The default of 400 divides the clock by 800.
- R2: Outside lamp test, a dark segment output equals `bp` and a lit segment output equals the inverse of `bp`.
- R3: Segment vectors use bit 0 = a, 1 = b, 2 = c, 3 = d, 4 = e, 5 = f, 6 = g, with 1 meaning lit. The codes 0..9 light these segments, in hex: 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F.
- R4: BCD codes 10 to 15 blank their digit (no segment lit).
- R5: `seg_lead` is a single combined b/c output for the leading half digit. It is lit when `lead_one` is 1.
- R6: `seg_minus` is lit when `negative` is 1.
- R7: The inputs are sampled only at the clock edge on which `bp` toggles. An input change between two toggles has no effect on any output until the next toggle.
- R8: When `overrange` is sampled as 1, `seg_lead` is lit and all three full digits are blank. `seg_minus` still follows `negative`.
- R9: While `lamp_test` is 1, all 23 segment outputs are a constant 1 from the next clock on, whatever `bp` does. After `lamp_test` is released, the next clock restores `bp` XOR the sampled pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bcd_units | input | 4 | Units digit code |
| bcd_tens | input | 4 | Tens digit code |
| bcd_hundreds | input | 4 | Hundreds digit code |
| lead_one | input | 1 | Leading half digit shows "1" |
| negative | input | 1 | Reading is negative |
| overrange | input | 1 | Reading exceeds full scale |
| lamp_test | input | 1 | Force all segments on, DC |
| bp | output | 1 | Backplane square wave |
| seg_units | output | 7 | Units segments a..g |
| seg_tens | output | 7 | Tens segments a..g |
| seg_hundreds | output | 7 | Hundreds segments a..g |
| seg_lead | output | 1 | Half digit combined b/c segment |
| seg_minus | output | 1 | Minus sign segment |

## Verification
The decoder is driven with all ten digit codes, spread over mixed triples. Each pattern is checked on two consecutive backplane phases, so a swapped segment bit and a wrong polarity relation fail different checks. Blank codes, the half digit, the sign and overrange are applied as separate patterns, which separates the blanking path from the decode path. A mid-phase input change, a measurement of the toggle period, and a lamp test held across a backplane transition tell sampling errors, divider errors and DC-override errors apart.

// File: rtl/lcd_drv_pkg.sv
package lcd_drv_pkg;
    localparam int SEG_W    = 7;
    localparam int NUM_FULL = 3;
    localparam int DISP_W   = NUM_FULL * SEG_W + 2;

    typedef logic [SEG_W-1:0] seg7_t;

    typedef struct packed {
        logic                     minus;
        logic                     lead;
        logic [NUM_FULL*SEG_W-1:0] full;  // hundreds, tens, units (units in low bits)
    } disp_t;

    // bit0 = a ... bit6 = g, 1 = lit
    function automatic seg7_t bcd_to_seg(input logic [3:0] code);
        seg7_t s;
        case (code)
            4'd0:    s = 7'h3F;
            4'd1:    s = 7'h06;
            4'd2:    s = 7'h5B;
            4'd3:    s = 7'h4F;
            4'd4:    s = 7'h66;
            4'd5:    s = 7'h6D;
            4'd6:    s = 7'h7D;
            4'd7:    s = 7'h07;
            4'd8:    s = 7'h7F;
            4'd9:    s = 7'h6F;
            default: s = 7'h00;
        endcase
        return s;
    endfunction
endpackage

// File: rtl/lcd_bp_gen.sv
module lcd_bp_gen #(
    parameter int HALF_DIV = 400
) (
    input  logic clk,
    input  logic rst_n,
    output logic bp_q_o,
    output logic toggle_o
);
    localparam int CW = (HALF_DIV > 2) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          bp;
    } bp_st_t;

    bp_st_t st_d, st_q;
    logic   wrap;

    always_comb begin
        st_d = st_q;
        wrap = (st_q.cnt == LAST);
        if (wrap) begin
            st_d.cnt = '0;
            st_d.bp  = ~st_q.bp;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bp_q_o   = st_q.bp;
    assign toggle_o = wrap;
endmodule

// File: rtl/lcd_digit_dec.sv
module lcd_digit_dec
    import lcd_drv_pkg::*;
#(
    parameter int NDIG = NUM_FULL
) (
    input  logic [NDIG*4-1:0]     codes,
    input  logic                  blank,
    output logic [NDIG*SEG_W-1:0] segs
);
    for (genvar g = 0; g < NDIG; g++) begin : g_dig
        seg7_t raw;
        always_comb begin
            raw = bcd_to_seg(codes[g*4 +: 4]);
            segs[g*SEG_W +: SEG_W] = blank ? '0 : raw;
        end
    end
endmodule

// File: rtl/lcd_seg_driver.sv
module lcd_seg_driver
    import lcd_drv_pkg::*;
#(
    parameter int HALF_DIV = 400
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] bcd_units,
    input  logic [3:0] bcd_tens,
    input  logic [3:0] bcd_hundreds,
    input  logic       lead_one,
    input  logic       negative,
    input  logic       overrange,
    input  logic       lamp_test,
    output logic       bp,
    output logic [6:0] seg_units,
    output logic [6:0] seg_tens,
    output logic [6:0] seg_hundreds,
    output logic       seg_lead,
    output logic       seg_minus
);
    typedef struct packed {
        disp_t pat;
        disp_t drv;
    } top_st_t;

    top_st_t                   st_d, st_q;
    logic                      bp_q, toggle, bp_next;
    logic [NUM_FULL*SEG_W-1:0] dec_segs;
    disp_t                     fresh;

    lcd_bp_gen #(.HALF_DIV(HALF_DIV)) u_bp (
        .clk     (clk),
        .rst_n   (rst_n),
        .bp_q_o  (bp_q),
        .toggle_o(toggle)
    );

    lcd_digit_dec #(.NDIG(NUM_FULL)) u_dec (
        .codes({bcd_hundreds, bcd_tens, bcd_units}),
        .blank(overrange),
        .segs (dec_segs)
    );

    always_comb begin
        fresh.full  = dec_segs;
        fresh.lead  = lead_one | overrange;
        fresh.minus = negative;
        bp_next     = bp_q ^ toggle;

        st_d = st_q;
        if (toggle) st_d.pat = fresh;
        if (lamp_test) st_d.drv = '1;
        else           st_d.drv = st_d.pat ^ {DISP_W{bp_next}};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bp           = bp_q;
    assign seg_units    = st_q.drv.full[0*SEG_W +: SEG_W];
    assign seg_tens     = st_q.drv.full[1*SEG_W +: SEG_W];
    assign seg_hundreds = st_q.drv.full[2*SEG_W +: SEG_W];
    assign seg_lead     = st_q.drv.lead;
    assign seg_minus    = st_q.drv.minus;
endmodule

// File: rtl/lcd_seg_driver_chk.sv
module lcd_seg_driver_chk #(
    parameter int HALF_DIV = 400
) (
    input logic       clk,
    input logic       rst_n,
    input logic       negative,
    input logic       overrange,
    input logic       lamp_test,
    input logic       bp,
    input logic [6:0] seg_units,
    input logic [6:0] seg_tens,
    input logic [6:0] seg_hundreds,
    input logic       seg_lead,
    input logic       seg_minus
);
    logic [22:0] segs;
    assign segs = {seg_minus, seg_lead, seg_hundreds, seg_tens, seg_units};

    // R1: backplane holds for at least two cycles after each toggle
    a_r1_bp_holds: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(bp) |=> $stable(bp));

    // R9: lamp test drives every segment to a constant 1
    a_r9_lamp_all_on: assert property (@(posedge clk) disable iff (!rst_n)
        $past(lamp_test) |-> (&segs));

    // R7: outside lamp transitions, segments move only with the backplane
    a_r7_only_on_bp_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(lamp_test) && !$past(lamp_test, 2) && $stable(bp)) |-> $stable(segs));

    // R8: overrange shows lead one and blanks the full digits
    a_r8_overrange_blank: assert property (@(posedge clk) disable iff (!rst_n)
        ($changed(bp) && !$past(lamp_test) && $past(overrange)) |->
        (seg_units == {7{bp}} && seg_tens == {7{bp}} &&
         seg_hundreds == {7{bp}} && seg_lead == !bp));

    // R6: minus follows the sampled sign, phase-modulated
    a_r6_minus_phase: assert property (@(posedge clk) disable iff (!rst_n)
        ($changed(bp) && !$past(lamp_test)) |-> (seg_minus == (bp ^ $past(negative))));
endmodule

bind lcd_seg_driver lcd_seg_driver_chk #(.HALF_DIV(HALF_DIV)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .negative    (negative),
    .overrange   (overrange),
    .lamp_test   (lamp_test),
    .bp          (bp),
    .seg_units   (seg_units),
    .seg_tens    (seg_tens),
    .seg_hundreds(seg_hundreds),
    .seg_lead    (seg_lead),
    .seg_minus   (seg_minus)
);

// File: tb/lcd_seg_driver_test.sv
module lcd_seg_driver_test;
    localparam int HALF = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0] bcd_units = '0, bcd_tens = '0, bcd_hundreds = '0;
    logic lead_one = 1'b0, negative = 1'b0, overrange = 1'b0, lamp_test = 1'b0;
    logic bp, seg_lead, seg_minus;
    logic [6:0] seg_units, seg_tens, seg_hundreds;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    lcd_seg_driver #(.HALF_DIV(HALF)) uut (
        .clk(clk), .rst_n(rst_n),
        .bcd_units(bcd_units), .bcd_tens(bcd_tens), .bcd_hundreds(bcd_hundreds),
        .lead_one(lead_one), .negative(negative), .overrange(overrange),
        .lamp_test(lamp_test), .bp(bp),
        .seg_units(seg_units), .seg_tens(seg_tens), .seg_hundreds(seg_hundreds),
        .seg_lead(seg_lead), .seg_minus(seg_minus)
    );

    typedef struct {
        string       tag;
        logic [23:0] exp;   // {bp, minus, lead, hundreds, tens, units}
    } item_t;

    item_t sb_q[$];
    event  chk_ev;
    logic [22:0] cur_pat;

    function automatic logic [6:0] ref_seg(input logic [3:0] c);
        case (c)
            0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
            4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
            8: return 7'h7F; 9: return 7'h6F;
            default: return 7'h00;
        endcase
    endfunction

    function automatic logic [22:0] ref_pat(input logic [3:0] h, input logic [3:0] t,
        input logic [3:0] u, input logic ld, input logic ng, input logic ov);
        if (ov) return {ng, 1'b1, 21'h0};
        return {ng, ld, ref_seg(h), ref_seg(t), ref_seg(u)};
    endfunction

    // monitor: pops expected items and compares against the ports
    initial begin
        forever begin
            @(chk_ev);
            while (sb_q.size() > 0) begin
                item_t it;
                logic [23:0] obs;
                it  = sb_q.pop_front();
                obs = {bp, seg_minus, seg_lead, seg_hundreds, seg_tens, seg_units};
                total++;
                if (obs !== it.exp) begin
                    bad++;
                    $display("FAIL %s: got %h expected %h", it.tag, obs, it.exp);
                end
            end
        end
    end

    task automatic push(input string tag, input logic [23:0] e);
        item_t it;
        it.tag = tag;
        it.exp = e;
        sb_q.push_back(it);
        -> chk_ev;
        #0;
    endtask

    task automatic wait_bp_change();
        logic b;
        b = bp;
        do @(negedge clk); while (bp == b);
    endtask

    // expect phase-modulated pattern at current bp
    task automatic push_phase(input string tag);
        push(tag, {bp, cur_pat ^ {23{bp}}});
    endtask

    // driver: apply right after a bp change, check two phases
    task automatic apply(input string tag, input logic [3:0] h, input logic [3:0] t,
        input logic [3:0] u, input logic ld, input logic ng, input logic ov);
        wait_bp_change();
        bcd_hundreds = h; bcd_tens = t; bcd_units = u;
        lead_one = ld; negative = ng; overrange = ov;
        wait_bp_change();
        cur_pat = ref_pat(h, t, u, ld, ng, ov);
        push_phase(tag);
        wait_bp_change();
        push_phase({tag, " R2 next phase"});
    endtask

    initial begin
        cur_pat = '0;
        repeat (3) @(negedge clk);
        push("R1 reset state", 24'h0);
        rst_n = 1'b1;

        // R1: toggle period
        begin
            int n;
            n = 0;
            do begin @(negedge clk); n++; end while (bp == 1'b0);
            total++;
            if (n != HALF) begin bad++; $display("FAIL R1 first half: got %0d expected %0d", n, HALF); end
            n = 0;
            do begin @(negedge clk); n++; end while (bp == 1'b1);
            total++;
            if (n != HALF) begin bad++; $display("FAIL R1 second half: got %0d expected %0d", n, HALF); end
        end

        apply("R3 digits 123", 4'd1, 4'd2, 4'd3, 1'b0, 1'b0, 1'b0);
        apply("R3 digits 456", 4'd4, 4'd5, 4'd6, 1'b0, 1'b0, 1'b0);
        apply("R3 digits 789", 4'd7, 4'd8, 4'd9, 1'b0, 1'b0, 1'b0);
        apply("R5 lead with 000", 4'd0, 4'd0, 4'd0, 1'b1, 1'b0, 1'b0);
        apply("R6 minus", 4'd9, 4'd0, 4'd5, 1'b0, 1'b1, 1'b0);
        apply("R4 blank codes", 4'd10, 4'd12, 4'd15, 1'b0, 1'b0, 1'b0);
        apply("R8 overrange", 4'd7, 4'd7, 4'd7, 1'b0, 1'b1, 1'b1);
        apply("R3 digits 312", 4'd3, 4'd1, 4'd2, 1'b1, 1'b1, 1'b0);

        // R7: mid-phase change is ignored until next toggle
        wait_bp_change();
        @(negedge clk);
        bcd_units = 4'd8; negative = 1'b0; lead_one = 1'b0;
        @(negedge clk);
        push_phase("R7 mid-phase change ignored");
        wait_bp_change();
        cur_pat = ref_pat(4'd3, 4'd1, 4'd8, 1'b0, 1'b0, 1'b0);
        push_phase("R7 change taken at toggle");

        // R9: lamp test
        @(negedge clk);
        lamp_test = 1'b1;
        @(negedge clk);
        push("R9 lamp all on", {bp, 23'h7FFFFF});
        wait_bp_change();
        push("R9 lamp held across toggle", {bp, 23'h7FFFFF});
        lamp_test = 1'b0;
        @(negedge clk);
        push_phase("R9 release restores drive");

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #100000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule